// File: doc/BRIEF.md
# Message-Signaled Interrupt Pending Bank

This block collects inbound message-signaled interrupts and keeps them as pending bits for the local processor. A transport layer that has already parsed the message hands over the message's vector number with a one-cycle valid strobe. The block decodes that number into a single bit of a 128-bit pending array. The array is held as four 32-bit words.

A single interrupt line goes to the processor and stays high while any pending bit is set. The processor drains the bank through a small read port. It selects a word with a 4-bit register number, and the words sit at numbers 8, 9, 10 and 11. The read returns the word one cycle later and clears that word at the same edge. A message that lands in the same cycle as the clear is never lost, and repeated messages for a bit that is already pending merge into that one bit.

Top module: `msi_pend_bank`

## Requirements
- R1: After a synchronous reset, all 128 pending bits are 0, `irq` is 0 and `rd_data` is 0x00000000.
- R2: A clock edge with `msg_valid` high sets exactly one pending bit. `msg_vec[6:5]` chooses the word (0..3) and `msg_vec[4:0]` chooses the bit position inside it. No other bit changes because of the message.
- R3: A read (`rd_en` high) with `rd_sel` equal to 8, 9, 10 or 11 targets word 0, 1, 2 or 3 respectively. `rd_data` shows that word's value from before the read edge, starting in the cycle after the strobe.
- R4: The edge that captures a read clears every pending bit of the selected word, so the clear is visible in the same cycle as the read data. The other three words are not touched.
- R5: If a message targets the word being read at the same edge, its bit is set after that edge. The returned read data does not include the new bit, and a later read returns it.
- R6: A message for a bit that is already pending leaves the whole pending array unchanged.
- R7: `irq` is registered and equals the OR of all pending bits as they stood one cycle earlier. It rises the cycle after the first bit is set and falls the cycle after the last bit is cleared.
- R8: A read with `rd_sel` outside 8..11 returns 0x00000000 and clears no pending bit.
- R9: `rd_data` holds its value in every cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Inbound message strobe, one cycle per message |
| msg_vec | input | 7 | Message vector number: [6:5] word, [4:0] bit |
| rd_en | input | 1 | Read strobe; also clears the selected word |
| rd_sel | input | 4 | Register number; 8..11 select words 0..3 |
| rd_data | output | 32 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | Registered interrupt line, high while any bit is pending |

## Verification
The bench aims at the edge where a message and a clear hit the same word. A design that applies the clear after the set would silently drop that interrupt. A design that ORs the new bit into the returned data would report it twice.

The bench also covers the following cases:
- It sends repeated messages to one bit. A design that treats a message as a toggle would then show the bit missing.
- It issues reads to register numbers outside the window. A design with a loose select decode would wipe or return a neighbouring word.
- It drains the last pending bit and watches the cycle in which `irq` falls. This catches an interrupt line driven from the next state instead of the held state, which would fall one cycle early.

// File: rtl/msi_pend_pkg.sv
package msi_pend_pkg;

  // Default geometry of the pending bank
  localparam int DEF_NUM_WORDS = 4;
  localparam int DEF_WORD_W    = 32;
  localparam int DEF_SEL_W     = 4;
  localparam int DEF_SEL_BASE  = 8;

  // Read port select decode result
  typedef struct packed {
    logic       hit;
    logic [3:0] off;
  } sel_dec_t;

endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int TOTAL = 128,
  parameter int VEC_W = $clog2(TOTAL)
) (
  input  logic             valid,
  input  logic [VEC_W-1:0] vec,
  output logic [TOTAL-1:0] set_mask
);

  // One-hot expansion of the message vector, gated by the strobe
  always_comb begin
    for (int i = 0; i < TOTAL; i++) begin
      set_mask[i] = valid && (vec == VEC_W'(i));
    end
  end

endmodule

// File: rtl/msi_pend_word.sv
module msi_pend_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_mask,
  input  logic              clr,
  output logic [WORD_W-1:0] pend
);

  // Clear first, then set: a message arriving with the clear survives
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~{WORD_W{clr}}) | set_mask;
    end
  end

endmodule

// File: rtl/msi_rd_port.sv
module msi_rd_port
  import msi_pend_pkg::*;
#(
  parameter int NUM_WORDS = DEF_NUM_WORDS,
  parameter int WORD_W    = DEF_WORD_W,
  parameter int SEL_W     = DEF_SEL_W,
  parameter int SEL_BASE  = DEF_SEL_BASE,
  localparam int TOTAL    = NUM_WORDS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [SEL_W-1:0]     rd_sel,
  input  logic [TOTAL-1:0]     words,
  output logic [NUM_WORDS-1:0] clr,
  output logic [WORD_W-1:0]    rd_data
);

  localparam logic [SEL_W-1:0] BASE_L = SEL_W'(SEL_BASE);
  localparam logic [SEL_W-1:0] CNT_L  = SEL_W'(NUM_WORDS);

  logic [SEL_W-1:0]  off;
  logic              hit;
  logic [WORD_W-1:0] sel_word;

  assign off = rd_sel - BASE_L;
  assign hit = (rd_sel >= BASE_L) && (off < CNT_L);

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      clr[k] = rd_en && hit && (off == SEL_W'(k));
      if (hit && off == SEL_W'(k)) begin
        sel_word = words[k*WORD_W +: WORD_W];
      end
    end
  end

  // Registered read data; held between strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= sel_word;
    end
  end

endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank
  import msi_pend_pkg::*;
#(
  parameter int NUM_WORDS = DEF_NUM_WORDS,
  parameter int WORD_W    = DEF_WORD_W,
  parameter int SEL_W     = DEF_SEL_W,
  parameter int SEL_BASE  = DEF_SEL_BASE,
  localparam int TOTAL    = NUM_WORDS * WORD_W,
  localparam int VEC_W    = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [VEC_W-1:0]  msg_vec,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);

  logic [TOTAL-1:0]     set_mask;
  logic [TOTAL-1:0]     pend_flat;
  logic [NUM_WORDS-1:0] clr;

  msi_vec_decode #(.TOTAL(TOTAL), .VEC_W(VEC_W)) u_dec (
    .valid    (msg_valid),
    .vec      (msg_vec),
    .set_mask (set_mask)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    msi_pend_word #(.WORD_W(WORD_W)) u_word (
      .clk      (clk),
      .rst      (rst),
      .set_mask (set_mask[w*WORD_W +: WORD_W]),
      .clr      (clr[w]),
      .pend     (pend_flat[w*WORD_W +: WORD_W])
    );
  end

  msi_rd_port #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .SEL_W     (SEL_W),
    .SEL_BASE  (SEL_BASE)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .words   (pend_flat),
    .clr     (clr),
    .rd_data (rd_data)
  );

  // Interrupt line registered from the held pending state
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= |pend_flat;
    end
  end

endmodule

// File: rtl/msi_pend_chk.sv
module msi_pend_chk #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int SEL_W     = 4,
  parameter int SEL_BASE  = 8,
  localparam int TOTAL    = NUM_WORDS * WORD_W,
  localparam int VEC_W    = $clog2(TOTAL)
) (
  input logic              clk,
  input logic              rst,
  input logic              msg_valid,
  input logic [VEC_W-1:0]  msg_vec,
  input logic              rd_en,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [WORD_W-1:0] rd_data,
  input logic              irq,
  input logic [TOTAL-1:0]  pend_flat
);

  function automatic logic [WORD_W-1:0] word_at(input logic [TOTAL-1:0] p, input int k);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (k >= 0 && k < NUM_WORDS) r[b] = p[k*WORD_W + b];
    end
    return r;
  endfunction

  int  c_off;
  logic c_hit;
  assign c_off = int'(rd_sel) - SEL_BASE;
  assign c_hit = (c_off >= 0) && (c_off < NUM_WORDS);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pend_flat == '0 && !irq && rd_data == '0));

  // R2
  msg_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(msg_valid) |-> pend_flat[$past(msg_vec)]);

  // R3
  read_data_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && c_hit) |-> rd_data == word_at($past(pend_flat), $past(c_off)));

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en && c_hit) && !$past(msg_valid)) |-> word_at(pend_flat, $past(c_off)) == '0);

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(msg_valid && rd_en && c_hit) |-> pend_flat[$past(msg_vec)]);

  // R6
  merge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(msg_valid && pend_flat[msg_vec]) && !$past(rd_en)) |-> $stable(pend_flat));

  // R7
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(|pend_flat));

  // R8
  miss_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !c_hit) |-> (rd_data == '0 && (($past(pend_flat) & ~pend_flat) == '0)));

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_en) && !$past(rst)) |-> $stable(rd_data));

endmodule

bind msi_pend_bank msi_pend_chk #(
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (WORD_W),
  .SEL_W     (SEL_W),
  .SEL_BASE  (SEL_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .msg_vec   (msg_vec),
  .rd_en     (rd_en),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .irq       (irq),
  .pend_flat (pend_flat)
);

// File: tb/tb_msi_pend_bank.sv
module tb_msi_pend_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [6:0]  msg_vec = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [127:0] m_pend = '0;
  logic [31:0]  m_rd   = '0;
  logic         m_irq  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  msi_pend_bank dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_vec(msg_vec),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic sel_hit(input logic [3:0] s);
    return (s >= 4'd8) && (s <= 4'd11);
  endfunction

  function automatic logic [31:0] mword(input logic [127:0] p, input logic [3:0] s);
    return sel_hit(s) ? p[(int'(s) - 8)*32 +: 32] : 32'h0;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(input string tag, input logic v, input logic [6:0] vec,
                      input logic r, input logic [3:0] s);
    logic [127:0] nxt;
    msg_valid = v; msg_vec = vec; rd_en = r; rd_sel = s;
    @(posedge clk);
    m_irq = |m_pend;
    nxt = m_pend;
    if (r) begin
      m_rd = mword(m_pend, s);
      if (sel_hit(s)) nxt[(int'(s) - 8)*32 +: 32] = 32'h0;
    end
    if (v) nxt[vec] = 1'b1;
    m_pend = nxt;
    @(negedge clk);
    check32({tag, " rd_data"}, rd_data, m_rd);
    check32({"R7 irq during ", tag}, {31'h0, irq}, {31'h0, m_irq});
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 7'h0, 1'b0, 4'h0);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check32("R1 rd_data", rd_data, 32'h0);
    check32("R1 irq", {31'h0, irq}, 32'h0);
    for (int s = 8; s < 12; s++) step("R1 read", 1'b0, 7'h0, 1'b1, 4'(s));

    // R2/R3: vector 37 -> word 1 bit 5, read through select 9
    step("R2 set", 1'b1, 7'd37, 1'b0, 4'h0);
    idle("R7 rise", 1);
    step("R3 read", 1'b0, 7'h0, 1'b1, 4'd9);
    check32("R2 onehot", rd_data, 32'h0000_0020);
    // R4: word now empty, irq falls next cycle
    idle("R7 fall", 2);
    step("R4 reread", 1'b0, 7'h0, 1'b1, 4'd9);
    check32("R4 cleared", rd_data, 32'h0);

    // R4: clearing word 0 leaves word 3 untouched
    step("R4 setA", 1'b1, 7'd2, 1'b0, 4'h0);
    step("R4 setB", 1'b1, 7'd127, 1'b0, 4'h0);
    step("R4 clr0", 1'b0, 7'h0, 1'b1, 4'd8);
    step("R4 rd3", 1'b0, 7'h0, 1'b1, 4'd11);
    check32("R4 other word", rd_data, 32'h8000_0000);

    // R5: message and clear on word 2 in the same edge
    step("R5 pre", 1'b1, 7'd64, 1'b0, 4'h0);
    step("R5 race", 1'b1, 7'd67, 1'b1, 4'd10);
    check32("R5 data excl new", rd_data, 32'h0000_0001);
    step("R5 after", 1'b0, 7'h0, 1'b1, 4'd10);
    check32("R5 survived", rd_data, 32'h0000_0008);

    // R6: repeated messages merge
    step("R6 a", 1'b1, 7'd5, 1'b0, 4'h0);
    step("R6 b", 1'b1, 7'd5, 1'b0, 4'h0);
    step("R6 c", 1'b1, 7'd5, 1'b0, 4'h0);
    step("R6 rd", 1'b0, 7'h0, 1'b1, 4'd8);
    check32("R6 merged", rd_data, 32'h0000_0020);

    // R8: out-of-window selects
    step("R8 set", 1'b1, 7'd96, 1'b0, 4'h0);
    step("R8 low", 1'b0, 7'h0, 1'b1, 4'd7);
    check32("R8 zero", rd_data, 32'h0);
    step("R8 high", 1'b0, 7'h0, 1'b1, 4'd12);
    step("R8 zero sel", 1'b0, 7'h0, 1'b1, 4'd0);
    step("R8 kept", 1'b0, 7'h0, 1'b1, 4'd11);
    check32("R8 not cleared", rd_data, 32'h0000_0001);

    // R9: hold between strobes
    idle("R9 hold", 3);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      step("R3 random", ($urandom % 3) != 0, 7'($urandom), ($urandom % 4) == 0,
           4'(6 + ($urandom % 8)));
    end
    for (int s = 8; s < 12; s++) step("R4 drain", 1'b0, 7'h0, 1'b1, 4'(s));
    idle("R7 drained", 2);
    check32("R7 low at end", {31'h0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule